// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block is the register-access front end of a two-channel serial controller. A host reaches eight byte-wide registers in each of two channels through a 3-bit register address and an 8-bit data path. The data path is split here into an input byte, an output byte and an output-enable that stands in for the pad tri-state control. A static mode pin chooses one of two bus styles.

In split-strobe style, separate active-low read and write strobes are used, and each channel has its own active-low select. In R/W style there is one select, a direction line and an extra address bit that picks the channel.

The block also produces the interrupt pins for the chosen style. In split-strobe style, each channel's interrupt pin is gated by bit 3 of that channel's modem control register. In R/W style, the pending requests of both channels are merged into one active-low request.

Top module: `dual_bus_if`

## Requirements
- R1: With `bus_mode`=1, a write happens when `wr_n` goes from 0 to 1 (sampled on consecutive clocks) while exactly one of `sel_a_n`/`sel_b_n` is low. `din` is stored into register `addr` of channel A (if `sel_a_n` is low) or channel B (if `sel_b_n` is low), and it can be read back from the next clock on.
- R2: With `bus_mode`=1, `rd_n`=0 and exactly one select low, `dout_oe` is 1 and `dout` shows register `addr` of the selected channel in the same cycle.
- R3: With `bus_mode`=1 and both selects low, no register is written and `dout_oe` stays 0.
- R4: With `bus_mode`=0, `rd_n` has no effect. A read is active while `sel_a_n`=0 and `wr_n`=1, and `sel_b_n` acts as address bit 3: 0 selects channel A and 1 selects channel B.
- R5: With `bus_mode`=0, a write happens when `sel_a_n` goes from 0 to 1 while `wr_n`=0. The channel is picked by `sel_b_n` as in R4.
- R6: `dout_oe` is 0 and `dout` is 0 whenever no valid read is in progress.
- R7: With `bus_mode`=1, `irq_a` follows `irq_pend_a` and `irq_b` follows `irq_pend_b`. Each of these pins is driven (its `_oe` is 1) only while bit 3 of that channel's register 4 is 1. `op2_a_n`/`op2_b_n` are the inverse of that same bit.
- R8: With `bus_mode`=0, `irq_a` is the active-low OR of `irq_pend_a` and `irq_pend_b` and is always driven. `irq_b` is driven to 0.
- R9: Reset is `rst_in`=1 when `bus_mode`=1 and `rst_in`=0 when `bus_mode`=0. Reset clears every register of both channels to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| bus_mode | input | 1 | 1 = split strobes, 0 = R/W style |
| rst_in | input | 1 | Reset, polarity set by bus_mode |
| addr | input | 3 | Register address |
| rd_n | input | 1 | Read strobe (split style only) |
| wr_n | input | 1 | Write strobe, or R/W in R/W style (1 = read) |
| sel_a_n | input | 1 | Channel A select, or the only select in R/W style |
| sel_b_n | input | 1 | Channel B select, or address bit 3 in R/W style |
| din | input | 8 | Write data |
| irq_pend_a | input | 1 | Channel A interrupt pending |
| irq_pend_b | input | 1 | Channel B interrupt pending |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Data bus drive enable |
| irq_a | output | 1 | Channel A interrupt, or combined active-low IRQ |
| irq_a_oe | output | 1 | Drive enable for irq_a |
| irq_b | output | 1 | Channel B interrupt, or constant 0 |
| irq_b_oe | output | 1 | Drive enable for irq_b |
| op2_a_n | output | 1 | Channel A output port 2 |
| op2_b_n | output | 1 | Channel B output port 2 |

## Verification
The assertions assume that `bus_mode` changes only while reset is held, with `rst_in` moved in the same cycle to the polarity that keeps reset active. They also assume that address, data and the channel pick are steady in the cycle where a strobe or select rises. The stimulus changes inputs only just after a clock edge. It changes the mode only inside a reset phase, and it holds every address and data value across each strobe.

// File: rtl/dual_bus_if.sv
module dual_bus_if #(
  parameter int DW       = 8,
  parameter int AW       = 3,
  parameter int GATE_IDX = 4,
  parameter int GATE_BIT = 3
) (
  input  logic          clk,
  input  logic          bus_mode,
  input  logic          rst_in,
  input  logic [AW-1:0] addr,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          sel_a_n,
  input  logic          sel_b_n,
  input  logic [DW-1:0] din,
  input  logic          irq_pend_a,
  input  logic          irq_pend_b,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          irq_a,
  output logic          irq_a_oe,
  output logic          irq_b,
  output logic          irq_b_oe,
  output logic          op2_a_n,
  output logic          op2_b_n
);
  localparam int NCH  = 2;
  localparam int NREG = 1 << AW;

  logic [NCH-1:0][NREG-1:0][DW-1:0] bank;
  logic wr_q, cs_q;

  wire rst_act   = bus_mode ? rst_in : ~rst_in;
  wire split_one = sel_a_n ^ sel_b_n;
  wire acc_ch    = bus_mode ? sel_a_n : sel_b_n;
  wire rd_go     = bus_mode ? (~rd_n & split_one) : (~sel_a_n & wr_n);
  wire wr_go     = bus_mode ? (~wr_q & wr_n & split_one)
                            : (~cs_q & sel_a_n & ~wr_n);
  wire gate_a    = bank[0][GATE_IDX][GATE_BIT];
  wire gate_b    = bank[1][GATE_IDX][GATE_BIT];

  always_ff @(posedge clk) begin
    if (rst_act) begin
      bank <= '0;
      wr_q <= 1'b1;
      cs_q <= 1'b1;
    end else begin
      wr_q <= wr_n;
      cs_q <= sel_a_n;
      if (wr_go) bank[acc_ch][addr] <= din;
    end
  end

  assign dout_oe  = rd_go;
  assign dout     = rd_go ? bank[acc_ch][addr] : '0;
  assign irq_a    = bus_mode ? irq_pend_a : ~(irq_pend_a | irq_pend_b);
  assign irq_a_oe = bus_mode ? gate_a : 1'b1;
  assign irq_b    = bus_mode & irq_pend_b;
  assign irq_b_oe = bus_mode ? gate_b : 1'b1;
  assign op2_a_n  = ~gate_a;
  assign op2_b_n  = ~gate_b;

  // R3
  dual_sel_block_chk: assert property (@(posedge clk) disable iff (rst_act)
    (bus_mode && !wr_q && wr_n && !sel_a_n && !sel_b_n) |=> $stable(bank));

  // R3
  dual_sel_no_oe_chk: assert property (@(posedge clk) disable iff (rst_act)
    (bus_mode && !sel_a_n && !sel_b_n) |-> !dout_oe);

  // R6
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst_act)
    !dout_oe |-> (dout == '0));

  // R4
  rw_rd_ignored_chk: assert property (@(posedge clk) disable iff (rst_act)
    (!bus_mode && sel_a_n) |-> !dout_oe);

  // R7
  op2_tracks_gate_chk: assert property (@(posedge clk) disable iff (rst_act)
    bus_mode |-> (irq_a_oe == !op2_a_n) && (irq_b_oe == !op2_b_n));

  // R8
  rw_irq_merge_chk: assert property (@(posedge clk) disable iff (rst_act)
    !bus_mode |-> (irq_a == !(irq_pend_a || irq_pend_b)) && !irq_b && irq_b_oe && irq_a_oe);
endmodule

// File: tb/test_dual_bus_if.sv
module test_dual_bus_if;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic bus_mode, rst_in, rd_n, wr_n, sel_a_n, sel_b_n, irq_pend_a, irq_pend_b;
  logic [2:0] addr;
  logic [7:0] din;
  logic [7:0] dout;
  logic dout_oe, irq_a, irq_a_oe, irq_b, irq_b_oe, op2_a_n, op2_b_n;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  dual_bus_if i_dual_bus_if (
    .clk(clk), .bus_mode(bus_mode), .rst_in(rst_in), .addr(addr),
    .rd_n(rd_n), .wr_n(wr_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
    .din(din), .irq_pend_a(irq_pend_a), .irq_pend_b(irq_pend_b),
    .dout(dout), .dout_oe(dout_oe), .irq_a(irq_a), .irq_a_oe(irq_a_oe),
    .irq_b(irq_b), .irq_b_oe(irq_b_oe), .op2_a_n(op2_a_n), .op2_b_n(op2_b_n));

  int m [2][8];
  int m_wr_q = 1, m_cs_q = 1;

  function automatic bit in_rst();
    return bus_mode ? rst_in : !rst_in;
  endfunction

  always @(posedge clk) begin
    if (in_rst()) begin
      foreach (m[c, r]) m[c][r] = 0;
      m_wr_q = 1; m_cs_q = 1;
    end else begin
      if (bus_mode == 1'b1) begin
        if (m_wr_q == 0 && wr_n && (sel_a_n != sel_b_n))
          m[sel_a_n ? 1 : 0][addr] = din;
      end else if (m_cs_q == 0 && sel_a_n && !wr_n) begin
        m[sel_b_n ? 1 : 0][addr] = din;
      end
      m_wr_q = wr_n; m_cs_q = sel_a_n;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished && !in_rst()) begin
      bit rd; int ch, ea, eaoe, eb, eboe, ga, gb;
      ga = (m[0][4] >> 3) & 1; gb = (m[1][4] >> 3) & 1;
      if (bus_mode) begin
        rd = !rd_n && (sel_a_n != sel_b_n); ch = sel_a_n ? 1 : 0;
        ea = irq_pend_a; eaoe = ga; eb = irq_pend_b; eboe = gb;
      end else begin
        rd = !sel_a_n && wr_n; ch = sel_b_n ? 1 : 0;
        ea = !(irq_pend_a || irq_pend_b); eaoe = 1; eb = 0; eboe = 1;
      end
      chk("R2/R4/R6 oe", dout_oe, rd);
      chk("R1/R5/R6 dout", dout, rd ? m[ch][addr] : 0);
      chk("R7/R8 irq_a", irq_a, ea);
      chk("R7/R8 irq_a_oe", irq_a_oe, eaoe);
      chk("R7/R8 irq_b", irq_b, eb);
      chk("R7/R8 irq_b_oe", irq_b_oe, eboe);
      chk("R7 op2_a_n", op2_a_n, !ga);
      chk("R7 op2_b_n", op2_b_n, !gb);
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic idle();
    rd_n = 1; wr_n = 1; sel_a_n = 1; sel_b_n = 1;
  endtask

  task automatic s_write(bit ch, int a, int d);
    addr = a[2:0]; din = d[7:0]; sel_a_n = ch; sel_b_n = !ch; wr_n = 0; tick();
    wr_n = 1; tick(); idle(); tick();
  endtask

  task automatic s_read(bit ch, int a, string tag, int exp);
    addr = a[2:0]; sel_a_n = ch; sel_b_n = !ch; rd_n = 0;
    @(negedge clk); chk(tag, dout_oe ? dout : -1, exp); tick(); idle(); tick();
  endtask

  task automatic r_write(bit ch, int a, int d);
    addr = a[2:0]; din = d[7:0]; sel_b_n = ch; wr_n = 0; sel_a_n = 0; tick();
    sel_a_n = 1; tick(); idle(); tick();
  endtask

  task automatic r_read(bit ch, int a, bit rdv, string tag, int exp);
    addr = a[2:0]; sel_b_n = ch; wr_n = 1; rd_n = rdv; sel_a_n = 0;
    @(negedge clk); chk(tag, dout_oe ? dout : -1, exp); tick(); idle(); tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(); addr = 0; din = 0; irq_pend_a = 0; irq_pend_b = 0;
    bus_mode = 1; rst_in = 1;
    #1; repeat (3) tick();
    rst_in = 0; tick();
    s_read(0, 0, "R9 reset A0", 0);
    s_read(1, 7, "R9 reset B7", 0);
    s_write(0, 2, 'h5A); s_write(1, 2, 'hA5); s_write(1, 7, 'h81);
    s_read(0, 2, "R1 R2 A2", 'h5A);
    s_read(1, 2, "R1 R2 B2", 'hA5);
    s_read(1, 7, "R1 R2 B7", 'h81);
    addr = 2; din = 'hFF; sel_a_n = 0; sel_b_n = 0; wr_n = 0; tick();
    wr_n = 1; tick(); rd_n = 0;
    @(negedge clk); chk("R3 dual select oe", dout_oe, 0); tick(); idle(); tick();
    s_read(0, 2, "R3 A2 kept", 'h5A);
    s_read(1, 2, "R3 B2 kept", 'hA5);
    @(negedge clk); chk("R7 gate off oe", irq_a_oe, 0); chk("R7 op2 off", op2_a_n, 1);
    s_write(0, 4, 'h08); irq_pend_a = 1; irq_pend_b = 1;
    @(negedge clk);
    chk("R7 gate on oe", irq_a_oe, 1); chk("R7 irq_a", irq_a, 1);
    chk("R7 op2_a low", op2_a_n, 0); chk("R7 B still off", irq_b_oe, 0);
    tick(); s_write(1, 4, 'hF7);
    @(negedge clk); chk("R7 B bit3 clear", irq_b_oe, 0); tick();
    irq_pend_a = 0; irq_pend_b = 0;

    bus_mode = 0; rst_in = 0; repeat (2) tick();
    rst_in = 1; tick();
    r_read(0, 2, 1, "R9 reset clears A2", 0);
    r_read(0, 4, 1, "R9 reset clears gate", 0);
    irq_pend_a = 1; @(negedge clk);
    chk("R8 merged irq", irq_a, 0); chk("R8 irq_b low", irq_b, 0); chk("R8 irq_b driven", irq_b_oe, 1);
    tick(); irq_pend_a = 0; irq_pend_b = 1; @(negedge clk); chk("R8 merged from B", irq_a, 0);
    tick(); irq_pend_b = 0; @(negedge clk); chk("R8 none pending", irq_a, 1); tick();
    r_write(0, 3, 'h3C); r_write(1, 3, 'hC3);
    r_read(0, 3, 1, "R5 R4 A3", 'h3C);
    r_read(1, 3, 0, "R5 R4 B3 rd_n ignored", 'hC3);
    rd_n = 0; sel_a_n = 1; @(negedge clk); chk("R4 R6 rd_n alone", dout_oe, 0); tick();
    sel_a_n = 0; wr_n = 0; @(negedge clk); chk("R6 write phase no oe", dout_oe, 0); tick();
    wr_n = 1; rd_n = 1; tick(); idle(); tick();
    r_read(0, 3, 0, "R5 cs rise without rw=0", 'h3C);
    rst_in = 0; tick(); rst_in = 1; tick();
    r_read(1, 3, 1, "R9 active-low reset", 0);
    repeat (3) tick();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule